// File: doc/BRIEF.md
# Bus Cycle Wait-State Controller

This block steps a processor bus cycle through the base states T1, T2, T3 and T4, and inserts wait states between T3 and T4. When a request arrives while the controller is idle, it captures three things: the region class of the access, that region's programmed wait-state code, and its ready-enable bit. It holds these for the rest of the cycle. It reports the current bus state, a wait flag and a one-clock cycle-done pulse.

Two external ready inputs are brought into the clock domain and OR-ed into one internal bus-ready signal. The first is an asynchronous input, which goes through a rising-edge flop and then a falling-edge flop. The second is a synchronous input, which goes through a single falling-edge flop.

When ready is required, the programmed wait count always runs to completion. Ready is judged once, at the sample point. If ready is missed there, the cycle holds in wait until ready appears and then adds one trailing wait.

Top module: `bus_wait_ctrl`

## Requirements
- R1: While reset is asserted and right after it, bus_state_o is 0 (idle), and wait_o and cycle_done_o are low.
- R2: The state codes are idle=0, T1=1, T2=2, T3=3, wait=4 and T4=5. With req_i high in idle, the next clock starts T1. The cycle then runs T1, T2, T3, W waits and T4, and then returns to idle, so a cycle lasts 4+W clocks. With req_i low, the controller stays idle. region_i, ws_code_i and rdy_en_i are captured on the clock that leaves idle.
- R3: For a narrow external region (region_i = 1 or 3), the programmed wait count is ws_code_i[1:0], which gives 0 to 3. ws_code_i[2] has no effect.
- R4: For the wide peripheral region (region_i = 2), codes 000 to 011 give 0 to 3 waits. Codes 100, 101, 110 and 111 give 5, 7, 9 and 15 waits.
- R5: For the internal memory region (region_i = 0), the cycle always has zero waits. The ready inputs and rdy_en_i have no effect.
- R6: For an external region with rdy_en_i low, the cycle has exactly the programmed count N of waits, whatever the ready inputs do.
- R7: With ready required, the sample point is the first wait state when N>0, and T3 when N=0. If bus ready is high at the sample point, the cycle has exactly N waits.
- R8: With ready required and bus ready low at the sample point, suppose bus ready is first seen high in wait number k (1-based). The cycle then has max(N, k+1) waits: one trailing wait after ready, and never fewer than the programmed count.
- R9: Bus ready is the OR of the two synchronized inputs. A synchronous-ready level driven from the start of a clock period counts for that same period. An asynchronous-ready level must be present one period earlier, because of its extra rising-edge flop.
- R10: wait_o is high in exactly the wait states. cycle_done_o is high for exactly one clock, in T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus cycle request |
| region_i | input | 2 | Region class: 0 internal, 1/3 narrow external, 2 wide peripheral |
| ws_code_i | input | 3 | Programmed wait-state code of the active region |
| rdy_en_i | input | 1 | Region requires external ready |
| ardy_i | input | 1 | Asynchronous external ready |
| srdy_i | input | 1 | Synchronous external ready |
| bus_state_o | output | 3 | Current bus state code |
| wait_o | output | 1 | Wait state active |
| cycle_done_o | output | 1 | One-clock pulse in T4 |

## Verification
The bench sweeps every region class, every code, both enable values, both ready sources and a range of ready arrival times. It checks the state in every clock of every cycle. It targets three kinds of design error:
- A controller that ends on late ready without the trailing wait, or that lets late ready cut the programmed count short, produces cycles that are too short for the wide codes.
- A narrow region that decodes bit 2, or an internal access that honours ready, shows wrong wait counts.
- An asynchronous path that is missing its rising-edge flop sees ready one clock early, and so shortens cycles whose arrival falls just past the sample point.

// File: rtl/bus_wait_pkg.sv
package bus_wait_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_st_e;

  localparam logic [1:0] RGN_INT  = 2'd0;
  localparam logic [1:0] RGN_WIDE = 2'd2;
endpackage

// File: rtl/ready_sync.sv
module ready_sync #(
  parameter bit ASYNC = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  output logic rdy_o
);
  generate
    if (ASYNC) begin : g_async
      logic rise_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rise_q <= 1'b0;
        else         rise_q <= rdy_i;
      end
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rdy_o <= 1'b0;
        else         rdy_o <= rise_q;
      end
    end else begin : g_sync
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rdy_o <= 1'b0;
        else         rdy_o <= rdy_i;
      end
    end
  endgenerate
endmodule

// File: rtl/ws_decode.sv
module ws_decode
  import bus_wait_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 4,
  parameter int WIDE4  = 5,
  parameter int WIDE5  = 7,
  parameter int WIDE6  = 9,
  parameter int WIDE7  = 15
) (
  input  logic [1:0]        region_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rdy_en_i,
  output logic [CNT_W-1:0]  ws_o,
  output logic              rdy_req_o
);
  localparam int NARROW_W = CODE_W - 1;

  logic [CNT_W-1:0] narrow_ws;
  logic [CNT_W-1:0] wide_ws;

  assign narrow_ws = CNT_W'(code_i[NARROW_W-1:0]);

  always_comb begin
    if (!code_i[CODE_W-1]) begin
      wide_ws = narrow_ws;
    end else begin
      unique case (code_i[1:0])
        2'd0:    wide_ws = CNT_W'(WIDE4);
        2'd1:    wide_ws = CNT_W'(WIDE5);
        2'd2:    wide_ws = CNT_W'(WIDE6);
        default: wide_ws = CNT_W'(WIDE7);
      endcase
    end
  end

  always_comb begin
    ws_o      = narrow_ws;
    rdy_req_o = rdy_en_i;
    if (region_i == RGN_INT) begin
      ws_o      = '0;
      rdy_req_o = 1'b0;
    end else if (region_i == RGN_WIDE) begin
      ws_o = wide_ws;
    end
  end
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bus_wait_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] ws_i,
  input  logic             rdy_req_i,
  input  logic             bus_rdy_i,
  output bus_st_e          state_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  bus_st_e          state_q;
  logic [CNT_W-1:0] ws_q;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             missed_q;
  logic             got_q;

  logic miss_now;
  logic may_end;

  // a miss is only judged at the first wait; the N=0 path arrives already missed
  assign miss_now = missed_q | ((cnt_q == CNT_ONE) & en_q & ~bus_rdy_i);
  assign may_end  = (~miss_now | got_q) & (cnt_q >= ws_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ws_q     <= '0;
      cnt_q    <= '0;
      en_q     <= 1'b0;
      missed_q <= 1'b0;
      got_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q  <= ST_T1;
          ws_q     <= ws_i;
          en_q     <= rdy_req_i;
          missed_q <= 1'b0;
          got_q    <= 1'b0;
          cnt_q    <= '0;
        end
        ST_T1: state_q <= ST_T2;
        ST_T2: state_q <= ST_T3;
        ST_T3: begin
          cnt_q <= CNT_ONE;
          if (ws_q != '0) begin
            state_q <= ST_TW;
          end else if (en_q && !bus_rdy_i) begin
            state_q  <= ST_TW;
            missed_q <= 1'b1;
          end else begin
            state_q <= ST_T4;
          end
        end
        ST_TW: begin
          if (may_end) begin
            state_q <= ST_T4;
          end else begin
            missed_q <= miss_now;
            if (miss_now && bus_rdy_i) got_q <= 1'b1;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
          end
        end
        ST_T4:   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bus_wait_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        region_i,
  input  logic [CODE_W-1:0] ws_code_i,
  input  logic              rdy_en_i,
  input  logic              ardy_i,
  input  logic              srdy_i,
  output logic [2:0]        bus_state_o,
  output logic              wait_o,
  output logic              cycle_done_o
);
  logic             ardy_s;
  logic             srdy_s;
  logic             bus_rdy;
  logic [CNT_W-1:0] ws;
  logic             rdy_req;
  bus_st_e          state;

  ready_sync #(.ASYNC(1'b1)) u_ardy_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .rdy_i(ardy_i), .rdy_o(ardy_s)
  );

  ready_sync #(.ASYNC(1'b0)) u_srdy_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .rdy_i(srdy_i), .rdy_o(srdy_s)
  );

  assign bus_rdy = ardy_s | srdy_s;

  ws_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_decode (
    .region_i (region_i),
    .code_i   (ws_code_i),
    .rdy_en_i (rdy_en_i),
    .ws_o     (ws),
    .rdy_req_o(rdy_req)
  );

  bus_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .ws_i     (ws),
    .rdy_req_i(rdy_req),
    .bus_rdy_i(bus_rdy),
    .state_o  (state)
  );

  assign bus_state_o  = state;
  assign wait_o       = (state == ST_TW);
  assign cycle_done_o = (state == ST_T4);
endmodule

// File: rtl/bus_wait_ctrl_chk.sv
module bus_wait_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [2:0] bus_state_o,
  input logic       wait_o,
  input logic       cycle_done_o
);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_state_o == 3'd0 && !req_i) |=> bus_state_o == 3'd0);
  // R2
  idle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_state_o == 3'd0 && req_i) |=> bus_state_o == 3'd1);
  // R2
  t1_to_t2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_state_o == 3'd1 |=> bus_state_o == 3'd2);
  // R2
  t4_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_state_o == 3'd5 |=> bus_state_o == 3'd0);
  // R2
  legal_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_state_o <= 3'd5);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_done_o |=> !cycle_done_o);
  // R10
  wait_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wait_o) |-> $past(bus_state_o) == 3'd3);
  // R10
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wait_o, cycle_done_o}));
endmodule

bind bus_wait_ctrl bus_wait_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .bus_state_o (bus_state_o),
  .wait_o      (wait_o),
  .cycle_done_o(cycle_done_o)
);

// File: tb/bus_wait_ctrl_tb.sv
module bus_wait_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [1:0] region = 2'd0;
  logic [2:0] code = 3'd0;
  logic       en = 1'b0;
  logic       ardy = 1'b0;
  logic       srdy = 1'b0;
  logic [2:0] state;
  logic       wt;
  logic       done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  bus_wait_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .region_i(region),
    .ws_code_i(code), .rdy_en_i(en), .ardy_i(ardy), .srdy_i(srdy),
    .bus_state_o(state), .wait_o(wt), .cycle_done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int prog_ws(input logic [1:0] r, input logic [2:0] c);
    if (r == 2'd0) return 0;
    if (r == 2'd2 && c[2]) begin
      case (c[1:0])
        2'd0: return 5;
        2'd1: return 7;
        2'd2: return 9;
        default: return 15;
      endcase
    end
    return int'(c[1:0]);
  endfunction

  // d: first wait index at which bus ready is visible (0 = already at T3)
  task automatic run_cycle(input logic [1:0] r, input logic [2:0] c, input logic e,
                           input int d, input bit use_async);
    int n, w, s, pos, waits, p_on, exp_st;
    bit ren;
    string tag;
    n   = prog_ws(r, c);
    ren = (r != 2'd0) && e;
    s   = (n > 0) ? 1 : 0;
    if (!ren || d <= s) w = n;
    else w = (n > d + 1) ? n : d + 1;
    if (r == 2'd0)     tag = "R5";
    else if (!ren)     tag = (r == 2'd2) ? "R4" : "R6";
    else if (d <= s)   tag = use_async ? "R9" : "R7";
    else               tag = use_async ? "R9" : "R8";
    if (r != 2'd0 && !ren && r != 2'd2) tag = (c[2]) ? "R3" : "R6";

    region = r; code = c; en = e; req = 1'b1; ardy = 1'b0; srdy = 1'b0;
    @(posedge clk); #1;
    req = 1'b0;
    region = ~r; code = ~c; en = ~e;  // captured values must persist
    p_on  = 3 + d;
    waits = 0;
    pos   = 1;
    while (pos < 80) begin
      if (use_async && pos == p_on - 1) ardy = 1'b1;
      if (!use_async && pos == p_on) srdy = 1'b1;
      exp_st = (pos <= 3) ? pos : ((pos <= 3 + w) ? 4 : 5);
      chk(int'(state) == exp_st, {tag, " state"}, int'(state), exp_st);
      chk(wt == (exp_st == 4), "R10 wait_o", int'(wt), int'(exp_st == 4));
      if (state == 3'd4) waits++;
      if (state == 3'd5 || state == 3'd0) break;
      @(posedge clk); #1;
      pos++;
    end
    chk(done == 1'b1, "R10 done", int'(done), 1);
    chk(waits == w, {tag, " waits"}, waits, w);
    chk(pos == 4 + w, "R2 length", pos, 4 + w);
    @(posedge clk); #1;
    ardy = 1'b0; srdy = 1'b0;
    chk(state == 3'd0 && !done, "R2 idle after T4", int'(state), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    int dl[6] = '{0, 1, 2, 3, 6, 17};
    #2;
    chk(state == 3'd0 && !wt && !done, "R1 in reset", int'(state), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(state == 3'd0 && !wt && !done, "R1 after reset", int'(state), 0);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      chk(state == 3'd0, "R2 no request", int'(state), 0);
    end
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 8; c++)
        for (int e = 0; e < 2; e++)
          for (int di = 0; di < 6; di++)
            for (int a = 0; a < 2; a++)
              run_cycle(2'(r), 3'(c), 1'(e), dl[di], a[0]);
    // region 3 behaves as narrow
    run_cycle(2'd3, 3'd6, 1'b0, 0, 1'b0);
    run_cycle(2'd3, 3'd7, 1'b1, 2, 1'b0);
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule